// File: doc/BRIEF.md
# Register-Driven Two-Wire Serial EEPROM Port

A host CPU runs a two-wire serial bus by software alone. Each write to one control register sets the clock line and the data line driven by the host side. Reading anywhere in a fixed address window returns the current level of the data line. Behind the port sits a complete serial EEPROM slave with a 256-byte internal array. The slave watches the lines that these writes produce. It finds START and STOP conditions and shifts in bits on rising clock edges. It checks the control byte against its device address, acknowledges bytes, stores written data, and sends stored data back on reads.

Both lines are open-drain and idle high. The data line is the wired AND of what the host drives and what the slave drives, so either side can pull it low and neither can force it high. Software builds every waveform itself: START, the data bits, the acknowledge beat, a repeated START and STOP. Nothing in the block makes timing of its own. Write-cycle busy time, page buffering and retention after power loss are not modelled.

Top module: `twowire_eeprom_port`

## Requirements
- R1: A write to address CTRL_ADDR (default 0x800D) sets the host clock output from data bit 5 and the host data output from data bit 6. Data bit 7 and bits 4..0 have no effect. A write to any other address leaves both lines unchanged.
- R2: A read is registered. One clock after a read strobe, `cpu_rdata` holds the resolved data line on bit 4 with all other bits 0 when the address is in 0x6000..0x7FFF. For any other address it holds 0x00.
- R3: After reset both lines are high and `cpu_rdata` is 0x00. The data line is low whenever either the host or the slave drives it low.
- R4: The slave treats a falling data line while the clock stays high as START, and a rising data line while the clock stays high as STOP. A STOP at any point returns the slave to idle, and a byte cut short by STOP is not stored.
- R5: The first byte after a START is a control byte, sent most significant bit first. When its top four bits are 1010 and bits 3..1 equal DEV_ADDR (default 000), the slave pulls the data line low in the ninth beat. Otherwise it does not.
- R6: The slave samples the data line on each rising clock edge. It changes its own data output only after a falling clock edge, that is, while the clock is low.
- R7: After a write control byte (bit 0 = 0), the next byte sets the word address. Each further byte is acknowledged and stored at that address, and the address then increments and wraps from 0xFF to 0x00.
- R8: After a read control byte (bit 0 = 1), the slave sends the byte at the current address and increments the address. A low acknowledge from the host requests the next byte. A high one ends the read, and the slave then drives nothing until the next START.
- R9: A repeated START (with no STOP before it) followed by a read control byte reads from the word address set just before it.
- R10: After a control byte that does not match, the slave acknowledges none of the following bytes and stores none of them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_wr | input | 1 | CPU write strobe |
| cpu_rd | input | 1 | CPU read strobe |
| cpu_addr | input | 16 | CPU address |
| cpu_wdata | input | 8 | CPU write data |
| cpu_rdata | output | 8 | Registered CPU read data |
| scl_line | output | 1 | Resolved clock line |
| sda_line | output | 1 | Resolved data line |

## Verification
The bench goes after the address wrap from 0xFF to 0x00. A design that failed to wrap would read back the wrong bytes after a long write. It also tests a STOP placed in the middle of a data byte. A slave that ignored that STOP would store a half byte over data written earlier. A repeated START with a read control byte must read from the word address set just before it; a slave that mishandled it would return bytes from the wrong place. After a control byte with a foreign device address or prefix, the bench checks that nothing is acknowledged or stored. A slave that matched too loosely would corrupt the array. After a high acknowledge ends a read, the bench clocks a further byte. A slave that kept sending would pull the line low and return data instead of 0xFF.

// File: rtl/twi_pkg.sv
package twi_pkg;
  localparam int TWI_ADDR_W = 16;
  localparam int SDA_BIT    = 6;
  localparam int SCL_BIT    = 5;
  localparam int RD_BIT     = 4;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CTRL,
    ST_WADDR,
    ST_WDATA,
    ST_READ
  } slave_state_t;

  // control byte matches prefix 1010 and the device address
  function automatic logic ctrl_match(input logic [7:0] b, input logic [2:0] dev);
    return (b[7:4] == 4'b1010) && (b[3:1] == dev);
  endfunction

  function automatic logic in_window(input logic [TWI_ADDR_W-1:0] a,
                                     input logic [TWI_ADDR_W-1:0] lo,
                                     input logic [TWI_ADDR_W-1:0] hi);
    return (a >= lo) && (a <= hi);
  endfunction

  function automatic logic [7:0] read_word(input logic line);
    logic [7:0] w;
    w = 8'h00;
    w[RD_BIT] = line;
    return w;
  endfunction

  // bit sent in beat n (0..7), most significant first
  function automatic logic tx_bit(input logic [7:0] b, input logic [3:0] n);
    return b[~n[2:0]];
  endfunction
endpackage

// File: rtl/twi_host_regs.sv
module twi_host_regs
  import twi_pkg::*;
#(
  parameter logic [TWI_ADDR_W-1:0] CTRL_ADDR = 16'h800D,
  parameter logic [TWI_ADDR_W-1:0] WIN_LO    = 16'h6000,
  parameter logic [TWI_ADDR_W-1:0] WIN_HI    = 16'h7FFF
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_en,
  input  logic                  rd_en,
  input  logic [TWI_ADDR_W-1:0] addr,
  input  logic                  wr_sda,
  input  logic                  wr_scl,
  input  logic                  sda_line,
  output logic [7:0]            rdata,
  output logic                  scl_m,
  output logic                  sda_m
);
  logic ctrl_hit;
  logic win_hit;

  assign ctrl_hit = wr_en && (addr == CTRL_ADDR);
  assign win_hit  = in_window(addr, WIN_LO, WIN_HI);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      scl_m <= 1'b1;
      sda_m <= 1'b1;
    end else if (ctrl_hit) begin
      scl_m <= wr_scl;
      sda_m <= wr_sda;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rdata <= 8'h00;
    end else if (rd_en) begin
      rdata <= win_hit ? read_word(sda_line) : 8'h00;
    end
  end
endmodule

// File: rtl/twi_line_resolve.sv
module twi_line_resolve (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_m,
  input  logic sda_m,
  input  logic sda_s,
  output logic scl_line,
  output logic sda_line,
  output logic ev_start,
  output logic ev_stop,
  output logic ev_rise,
  output logic ev_fall
);
  logic scl_q;
  logic sda_q;

  // open-drain lines: only the host drives the clock, both share data
  assign scl_line = scl_m;
  assign sda_line = sda_m & sda_s;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_line;
      sda_q <= sda_line;
    end
  end

  assign ev_start = scl_line & scl_q & sda_q & ~sda_line;
  assign ev_stop  = scl_line & scl_q & ~sda_q & sda_line;
  assign ev_rise  = scl_line & ~scl_q;
  assign ev_fall  = ~scl_line & scl_q;
endmodule

// File: rtl/twi_eeprom_slave.sv
module twi_eeprom_slave
  import twi_pkg::*;
#(
  parameter int         MEM_AW   = 8,
  parameter logic [2:0] DEV_ADDR = 3'b000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sda_line,
  input  logic              ev_start,
  input  logic              ev_stop,
  input  logic              ev_rise,
  input  logic              ev_fall,
  output logic              sda_s,
  output logic              idle_o,
  output logic              mem_we_o,
  output logic [MEM_AW-1:0] ptr_o
);
  localparam int DEPTH = 1 << MEM_AW;

  slave_state_t      state;
  logic [3:0]        cnt;
  logic [7:0]        shreg;
  logic [7:0]        tx;
  logic              ack_go;
  logic              rw;
  logic [MEM_AW-1:0] ptr;
  logic [7:0]        mem [DEPTH];
  logic [7:0]        rx_byte;
  logic              receiving;
  logic              sda_next;

  assign rx_byte   = {shreg[6:0], sda_line};
  assign receiving = (state == ST_CTRL) || (state == ST_WADDR) || (state == ST_WDATA);
  assign mem_we_o  = ev_rise && (state == ST_WDATA) && (cnt == 4'd7);
  assign idle_o    = (state == ST_IDLE);
  assign ptr_o     = ptr;

  // value the slave presents after the next falling clock
  always_comb begin
    sda_next = 1'b1;
    if (state == ST_READ && cnt < 4'd8)
      sda_next = tx_bit(tx, cnt);
    else if (receiving && cnt == 4'd8 && ack_go)
      sda_next = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (mem_we_o) mem[ptr] <= rx_byte;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state  <= ST_IDLE;
      cnt    <= 4'd0;
      shreg  <= 8'h00;
      tx     <= 8'hFF;
      ack_go <= 1'b0;
      rw     <= 1'b0;
      ptr    <= '0;
      sda_s  <= 1'b1;
    end else if (ev_start) begin
      state  <= ST_CTRL;
      cnt    <= 4'd0;
      ack_go <= 1'b0;
      sda_s  <= 1'b1;
    end else if (ev_stop) begin
      state  <= ST_IDLE;
      cnt    <= 4'd0;
      ack_go <= 1'b0;
      sda_s  <= 1'b1;
    end else if (ev_fall) begin
      sda_s <= sda_next;
    end else if (ev_rise && state != ST_IDLE) begin
      if (cnt == 4'd8) begin
        cnt    <= 4'd0;
        ack_go <= 1'b0;
        case (state)
          ST_CTRL: begin
            if (rw) begin
              state <= ST_READ;
              tx    <= mem[ptr];
            end else begin
              state <= ST_WADDR;
            end
          end
          ST_WADDR: state <= ST_WDATA;
          ST_READ: begin
            if (!sda_line) tx <= mem[ptr];
            else           state <= ST_IDLE;
          end
          default: state <= state;
        endcase
      end else if (receiving) begin
        shreg <= rx_byte;
        cnt   <= cnt + 4'd1;
        if (cnt == 4'd7) begin
          case (state)
            ST_CTRL: begin
              if (ctrl_match(rx_byte, DEV_ADDR)) begin
                ack_go <= 1'b1;
                rw     <= rx_byte[0];
              end else begin
                state <= ST_IDLE;
              end
            end
            ST_WADDR: begin
              ptr    <= rx_byte[MEM_AW-1:0];
              ack_go <= 1'b1;
            end
            default: begin
              ptr    <= ptr + 1'b1;
              ack_go <= 1'b1;
            end
          endcase
        end
      end else begin
        cnt <= cnt + 4'd1;
        if (cnt == 4'd7) ptr <= ptr + 1'b1;
      end
    end
  end
endmodule

// File: rtl/twowire_eeprom_port.sv
module twowire_eeprom_port
  import twi_pkg::*;
#(
  parameter logic [TWI_ADDR_W-1:0] CTRL_ADDR = 16'h800D,
  parameter logic [TWI_ADDR_W-1:0] WIN_LO    = 16'h6000,
  parameter logic [TWI_ADDR_W-1:0] WIN_HI    = 16'h7FFF,
  parameter int                    MEM_AW    = 8,
  parameter logic [2:0]            DEV_ADDR  = 3'b000
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cpu_wr,
  input  logic        cpu_rd,
  input  logic [15:0] cpu_addr,
  input  logic [7:0]  cpu_wdata,
  output logic [7:0]  cpu_rdata,
  output logic        scl_line,
  output logic        sda_line
);
  logic              scl_m;
  logic              sda_m;
  logic              sda_s;
  logic              ev_start;
  logic              ev_stop;
  logic              ev_rise;
  logic              ev_fall;
  logic              slave_idle;
  logic              mem_we;
  logic [MEM_AW-1:0] ptr;
  logic              unused_wbits;

  assign unused_wbits = ^{cpu_wdata[7], cpu_wdata[4:0]};

  twi_host_regs #(
    .CTRL_ADDR(CTRL_ADDR), .WIN_LO(WIN_LO), .WIN_HI(WIN_HI)
  ) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(cpu_wr), .rd_en(cpu_rd), .addr(cpu_addr),
    .wr_sda(cpu_wdata[SDA_BIT]), .wr_scl(cpu_wdata[SCL_BIT]), .sda_line(sda_line),
    .rdata(cpu_rdata), .scl_m(scl_m), .sda_m(sda_m)
  );

  twi_line_resolve u_lines (
    .clk(clk), .rst_n(rst_n), .scl_m(scl_m), .sda_m(sda_m), .sda_s(sda_s),
    .scl_line(scl_line), .sda_line(sda_line), .ev_start(ev_start),
    .ev_stop(ev_stop), .ev_rise(ev_rise), .ev_fall(ev_fall)
  );

  twi_eeprom_slave #(
    .MEM_AW(MEM_AW), .DEV_ADDR(DEV_ADDR)
  ) u_slave (
    .clk(clk), .rst_n(rst_n), .sda_line(sda_line), .ev_start(ev_start),
    .ev_stop(ev_stop), .ev_rise(ev_rise), .ev_fall(ev_fall), .sda_s(sda_s),
    .idle_o(slave_idle), .mem_we_o(mem_we), .ptr_o(ptr)
  );
endmodule

// File: rtl/twi_port_checker.sv
module twi_port_checker
  import twi_pkg::*;
#(
  parameter logic [TWI_ADDR_W-1:0] CTRL_ADDR = 16'h800D,
  parameter logic [TWI_ADDR_W-1:0] WIN_LO    = 16'h6000,
  parameter logic [TWI_ADDR_W-1:0] WIN_HI    = 16'h7FFF,
  parameter int                    MEM_AW    = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cpu_wr,
  input logic              cpu_rd,
  input logic [15:0]       cpu_addr,
  input logic [7:0]        cpu_wdata,
  input logic [7:0]        cpu_rdata,
  input logic              scl_line,
  input logic              sda_line,
  input logic              sda_m,
  input logic              sda_s,
  input logic              ev_start,
  input logic              ev_stop,
  input logic              slave_idle,
  input logic              mem_we,
  input logic [MEM_AW-1:0] ptr
);
  assert_clock_from_bit5_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_wr && cpu_addr == CTRL_ADDR) |=> (scl_line == $past(cpu_wdata[SCL_BIT])));

  assert_other_addr_ignored_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (!(cpu_wr && cpu_addr == CTRL_ADDR)) |=> $stable(scl_line));

  assert_outside_window_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_rd && !in_window(cpu_addr, WIN_LO, WIN_HI)) |=> (cpu_rdata == 8'h00));

  assert_window_bit4_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_rd && in_window(cpu_addr, WIN_LO, WIN_HI)) |=>
      (cpu_rdata[RD_BIT] == $past(sda_line)) && (cpu_rdata[7:5] == 3'b000));

  assert_wired_and_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!sda_m || !sda_s) |-> !sda_line);

  assert_stop_to_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ev_stop |=> slave_idle);

  assert_start_leaves_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ev_start |=> !slave_idle);

  assert_idle_releases_R5: assert property (@(posedge clk) disable iff (!rst_n)
    slave_idle |-> sda_s);

  assert_change_while_low_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_s) |-> !$past(scl_line));

  assert_ptr_advance_R7: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |=> (ptr == $past(ptr) + 1'b1));
endmodule

bind twowire_eeprom_port twi_port_checker #(
  .CTRL_ADDR(CTRL_ADDR), .WIN_LO(WIN_LO), .WIN_HI(WIN_HI), .MEM_AW(MEM_AW)
) u_chk (
  .clk(clk), .rst_n(rst_n), .cpu_wr(cpu_wr), .cpu_rd(cpu_rd), .cpu_addr(cpu_addr),
  .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata), .scl_line(scl_line),
  .sda_line(sda_line), .sda_m(sda_m), .sda_s(sda_s), .ev_start(ev_start),
  .ev_stop(ev_stop), .slave_idle(slave_idle), .mem_we(mem_we), .ptr(ptr)
);

// File: tb/twowire_eeprom_port_bench.sv
`timescale 1ns/1ps
module twowire_eeprom_port_bench;
  localparam logic [15:0] CTRL = 16'h800D;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cpu_wr = 1'b0;
  logic        cpu_rd = 1'b0;
  logic [15:0] cpu_addr = 16'h0000;
  logic [7:0]  cpu_wdata = 8'h00;
  logic [7:0]  cpu_rdata;
  logic        scl_line;
  logic        sda_line;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  bit junk7 = 1'b0;

  always #2.5 clk = ~clk;

  twowire_eeprom_port u_twowire_eeprom_port (
    .clk(clk), .rst_n(rst_n), .cpu_wr(cpu_wr), .cpu_rd(cpu_rd), .cpu_addr(cpu_addr),
    .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata), .scl_line(scl_line), .sda_line(sda_line)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic cpu_write(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    cpu_wr = 1'b1; cpu_addr = a; cpu_wdata = d;
    @(negedge clk);
    cpu_wr = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic cpu_read(input logic [15:0] a, output logic [7:0] d);
    @(negedge clk);
    cpu_rd = 1'b1; cpu_addr = a;
    @(negedge clk);
    cpu_rd = 1'b0;
    d = cpu_rdata;
  endtask

  // bit 7 toggles on every write; it must not matter
  task automatic bus(input bit scl, input bit sda);
    junk7 = ~junk7;
    cpu_write(CTRL, {junk7, sda, scl, 5'b10101});
  endtask

  task automatic line_bit(output bit b);
    logic [7:0] d;
    cpu_read(16'h6000, d);
    b = d[4];
  endtask

  task automatic do_start();
    bus(0, 1); bus(1, 1); bus(1, 0); bus(0, 0);
  endtask

  task automatic do_stop();
    bus(0, 0); bus(1, 0); bus(1, 1);
  endtask

  task automatic send_byte(input logic [7:0] b, output bit acked);
    bit s;
    for (int i = 7; i >= 0; i--) begin
      bus(0, b[i]); bus(1, b[i]); bus(0, b[i]);
    end
    bus(0, 1); bus(1, 1);
    line_bit(s);
    acked = !s;
    bus(0, 1);
  endtask

  task automatic recv_byte(input bit nack, output logic [7:0] b);
    bit s;
    for (int i = 7; i >= 0; i--) begin
      bus(0, 1); bus(1, 1);
      line_bit(s);
      b[i] = s;
      bus(0, 1);
    end
    bus(0, nack); bus(1, nack); bus(0, nack);
  endtask

  task automatic write_bytes(input logic [7:0] wa, input logic [7:0] d0,
                             input logic [7:0] d1, input int n, input string req);
    bit a;
    do_start();
    send_byte(8'hA0, a); check(a, "R5 write control ack", a, 1);
    send_byte(wa, a);    check(a, {req, " word address ack"}, a, 1);
    send_byte(d0, a);    check(a, {req, " data ack"}, a, 1);
    if (n > 1) begin
      send_byte(d1, a);  check(a, {req, " data ack"}, a, 1);
    end
    do_stop();
  endtask

  // set address, repeated START, read one or two bytes
  task automatic random_read(input logic [7:0] wa, input int n,
                             output logic [7:0] r0, output logic [7:0] r1);
    bit a;
    do_start();
    send_byte(8'hA0, a); check(a, "R9 control ack", a, 1);
    send_byte(wa, a);    check(a, "R9 address ack", a, 1);
    do_start();
    send_byte(8'hA1, a); check(a, "R9 read control ack after repeated start", a, 1);
    recv_byte(n == 1, r0);
    r1 = 8'hXX;
    if (n > 1) recv_byte(1'b1, r1);
    do_stop();
  endtask

  task automatic t_reset();
    logic [7:0] d;
    check(scl_line == 1'b1, "R3 clock idle high", scl_line, 1);
    check(sda_line == 1'b1, "R3 data idle high", sda_line, 1);
    check(cpu_rdata == 8'h00, "R3 read data reset", cpu_rdata, 0);
    cpu_read(16'h7000, d);
    check(d == 8'h10, "R2 window read idle line", d, 8'h10);
  endtask

  task automatic t_register_map();
    logic [7:0] d;
    cpu_write(CTRL, 8'b1010_0000);        // bit7=1, sda=0, scl=1
    check(scl_line == 1'b1 && sda_line == 1'b0, "R1 bit6/bit5 map", {scl_line, sda_line}, 2);
    cpu_read(16'h6000, d);
    check(d == 8'h00, "R2 low line reads bit4 = 0", d, 0);
    cpu_write(16'h800C, 8'h40);           // other address: no effect
    check(scl_line == 1'b1 && sda_line == 1'b0, "R1 other address ignored", {scl_line, sda_line}, 2);
    cpu_write(CTRL, 8'b0111_1111);        // bit7=0, sda=1, scl=1
    check(scl_line == 1'b1 && sda_line == 1'b1, "R1 lines high again", {scl_line, sda_line}, 3);
    cpu_read(16'h7FFF, d);
    check(d == 8'h10, "R2 top of window", d, 8'h10);
    cpu_read(16'h8000, d);
    check(d == 8'h00, "R2 above window", d, 0);
    cpu_read(16'h5FFF, d);
    check(d == 8'h00, "R2 below window", d, 0);
  endtask

  task automatic t_write_and_read();
    logic [7:0] r0, r1;
    write_bytes(8'h10, 8'h5A, 8'hC3, 2, "R7");
    random_read(8'h10, 2, r0, r1);
    check(r0 == 8'h5A, "R8 first read byte", r0, 8'h5A);
    check(r1 == 8'hC3, "R8 incremented read byte", r1, 8'hC3);
  endtask

  task automatic t_wrap();
    logic [7:0] r0, r1;
    bit a;
    do_start();
    send_byte(8'hA0, a); check(a, "R7 control ack", a, 1);
    send_byte(8'hFF, a); check(a, "R7 address ack", a, 1);
    send_byte(8'h11, a); check(a, "R7 byte at 0xFF", a, 1);
    send_byte(8'h22, a); check(a, "R7 byte at 0x00", a, 1);
    send_byte(8'h33, a); check(a, "R7 byte at 0x01", a, 1);
    do_stop();
    random_read(8'hFF, 2, r0, r1);
    check(r0 == 8'h11, "R7 wrap read 0xFF", r0, 8'h11);
    check(r1 == 8'h22, "R7 wrap read 0x00", r1, 8'h22);
    // current-address read continues at 0x01
    do_start();
    send_byte(8'hA1, a); check(a, "R8 current read ack", a, 1);
    recv_byte(1'b1, r0);
    do_stop();
    check(r0 == 8'h33, "R8 current address read", r0, 8'h33);
  endtask

  task automatic t_nack_ends_read();
    logic [7:0] r0, r1;
    bit a;
    do_start();
    send_byte(8'hA1, a); check(a, "R8 read control ack", a, 1);
    recv_byte(1'b1, r0);
    recv_byte(1'b1, r1);                  // slave must stay silent
    do_stop();
    check(r1 == 8'hFF, "R8 no drive after high acknowledge", r1, 8'hFF);
  endtask

  task automatic t_wrong_device();
    logic [7:0] r0, r1;
    bit a;
    do_start();
    send_byte(8'hA2, a); check(!a, "R5 foreign device address not acked", a, 0);
    send_byte(8'h10, a); check(!a, "R10 following byte not acked", a, 0);
    send_byte(8'h99, a); check(!a, "R10 data not acked", a, 0);
    do_stop();
    do_start();
    send_byte(8'hB0, a); check(!a, "R5 wrong prefix not acked", a, 0);
    send_byte(8'h10, a); check(!a, "R10 byte after wrong prefix", a, 0);
    do_stop();
    random_read(8'h10, 1, r0, r1);
    check(r0 == 8'h5A, "R10 memory untouched", r0, 8'h5A);
  endtask

  task automatic t_stop_mid_byte();
    logic [7:0] r0, r1;
    bit a;
    write_bytes(8'h40, 8'h66, 8'h00, 1, "R4");
    do_start();
    send_byte(8'hA0, a); check(a, "R4 control ack", a, 1);
    send_byte(8'h40, a); check(a, "R4 address ack", a, 1);
    for (int i = 0; i < 4; i++) begin
      bus(0, 1); bus(1, 1); bus(0, 1);
    end
    do_stop();
    random_read(8'h40, 1, r0, r1);
    check(r0 == 8'h66, "R4 partial byte not stored", r0, 8'h66);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual 0x0 expected 0x1");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_register_map();
    t_write_and_read();
    t_wrap();
    t_nack_ends_read();
    t_wrong_device();
    t_stop_mid_byte();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule